// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources (sixteen by default) and presents a processor core with one 3-bit encoded request level, where 0 means idle, 1 is the lowest level and 7 the highest. Every source has its own control register holding a request level and a sub-priority within that level. A per-source mask register and a global mask-all bit block sources. Among the sources still eligible, the highest level wins. A tie at the same level goes to the highest sub-priority, and a tie there goes to the lowest source index.

Levels 1 to 6 are level-sensitive and are not latched: the source holds its request until software clears it at the source. The core's 3-bit mask gates them, so an interrupt is taken only when the presented level is strictly above that mask. Level 7 cannot be masked by the core and reacts to edges. A rising request edge on a level-7 source sets a pending bit, and an acknowledge of that source clears it. The core acknowledges with a hardware cycle that names a level, or with a software read of an acknowledge address for a level. Either way the block returns a vector unique to the winning source, or a spurious vector when nothing qualifies. A wake-up output flags a request the core would take while it sits in a low-power stop mode.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all control registers read 0 (sources disabled), the mask register (address NSRC) reads all ones, the mask-all bit (address NSRC+1, bit 0) reads 1, irq_level is 0, take_irq and wake are 0, and hw_vector is the spurious value 24.
- R2: Control register i is at address i: bits [5:3] hold the level and bits [2:0] hold the sub-priority. It reads back what was written, and a level of 0 keeps the source out of arbitration.
- R3: irq_level shows the highest level among eligible sources one clock after the request and configuration are in place. A level 1 to 6 source that drops its request drops out, because nothing is latched.
- R4: For levels 1 to 6, take_irq is 1 exactly when irq_level is strictly greater than cpu_mask.
- R5: A level-7 source becomes pending on a rising edge of its request and stays pending until acknowledged, even after the request falls. take_irq pulses for one cycle when irq_level first becomes 7, whatever the value of cpu_mask. A request held high after acknowledge does not trigger again.
- R6: Setting bit i of the mask register blocks source i, and setting the mask-all bit blocks every source.
- R7: Within one level, the higher sub-priority wins, and among equal sub-priorities the lowest source index wins.
- R8: While hw_ack is 1, hw_vector is 64 plus the index of the winning eligible source at level hw_ack_level, or 24 if there is none. An acknowledge at level 7 clears that source's pending bit at the clock edge.
- R9: A read of address NSRC+8+L returns the vector for level L, computed under the same rule as R8. A read strobe at L=7 clears the pending bit of the source it returns.
- R10: wake is 1 exactly when stop_mode is 1 and irq_level is either 7 or greater than cpu_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NSRC | Request line per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only on level-7 acknowledge reads) |
| reg_addr | input | AW | Register address |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data (combinational) |
| cpu_mask | input | 3 | Core's current interrupt mask |
| stop_mode | input | 1 | Core is in low-power stop mode |
| irq_level | output | 3 | Encoded request level to the core |
| take_irq | output | 1 | Core should take an interrupt |
| hw_ack | input | 1 | Hardware acknowledge cycle |
| hw_ack_level | input | 3 | Level being acknowledged |
| hw_vector | output | 8 | Vector returned for the hardware acknowledge |
| wake | output | 1 | Wake-up request in stop mode |

## Verification
On every cycle, the checker confirms four things: the mask comparison on take_irq, the one-cycle pulse of a level-7 take, the global mask-all bit forcing the level to 0 on the next cycle, and wake staying low outside stop mode. It also checks that every hardware vector is either spurious or inside the source range. Which source actually wins, including the sub-priority and index tie-breaks, the latching and clearing of level-7 pending bits by both acknowledge paths, and register readback all depend on history. Only the bench's scenarios can show these, with its reference model tracking the configuration.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef struct packed {
        logic [2:0] lvl;
        logic [2:0] sub;
    } ctrl_t;

    localparam logic [2:0] LVL_NMI = 3'd7;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int AW   = 5,
    parameter int IW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [NSRC-1:0]      reg_wdata,
    input  logic [NSRC-1:0]      src_req,
    input  logic                 clr7_en,
    input  logic [IW-1:0]        clr7_idx,
    output ctrl_t [NSRC-1:0]     ctrl,
    output logic [NSRC-1:0]      mask,
    output logic                 gmask,
    output logic [NSRC-1:0]      elig
);
    localparam int MASK_ADDR  = NSRC;
    localparam int GMASK_ADDR = NSRC + 1;

    typedef struct packed {
        ctrl_t [NSRC-1:0] ctrl;
        logic [NSRC-1:0]  mask;
        logic             gmask;
        logic [NSRC-1:0]  req;
        logic [NSRC-1:0]  p7;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (int'(reg_addr) < NSRC)
                st_d.ctrl[reg_addr[IW-1:0]] = ctrl_t'(reg_wdata[5:0]);
            else if (int'(reg_addr) == MASK_ADDR)
                st_d.mask = reg_wdata;
            else if (int'(reg_addr) == GMASK_ADDR)
                st_d.gmask = reg_wdata[0];
        end
        st_d.req = src_req;
        for (int i = 0; i < NSRC; i++) begin
            if (clr7_en && clr7_idx == IW'(i))
                st_d.p7[i] = 1'b0;
            if (src_req[i] && !st_q.req[i] && st_q.ctrl[i].lvl == LVL_NMI)
                st_d.p7[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.mask  <= '1;
            st_q.gmask <= 1'b1;
            st_q.req   <= '0;
            st_q.p7    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        logic active;
        assign active  = (st_q.ctrl[g].lvl == LVL_NMI) ? st_q.p7[g] : src_req[g];
        assign elig[g] = active && (st_q.ctrl[g].lvl != 3'd0)
                         && !st_q.mask[g] && !st_q.gmask;
    end

    assign ctrl  = st_q.ctrl;
    assign mask  = st_q.mask;
    assign gmask = st_q.gmask;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int IW   = 4
) (
    input  ctrl_t [NSRC-1:0] ctrl,
    input  logic [NSRC-1:0]  elig,
    input  logic             filt_en,
    input  logic [2:0]       filt_lvl,
    output logic             valid,
    output logic [IW-1:0]    idx,
    output logic [2:0]       lvl
);
    ctrl_t best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!filt_en || ctrl[i].lvl == filt_lvl)
                && (!valid || ctrl[i] > best)) begin
                valid = 1'b1;
                best  = ctrl[i];
                idx   = IW'(i);
            end
        end
        lvl = best.lvl;
    end
endmodule

// File: rtl/irq_core_if.sv
module irq_core_if
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_valid,
    input  logic [2:0] win_lvl,
    input  logic [2:0] cpu_mask,
    input  logic       stop_mode,
    output logic [2:0] irq_level,
    output logic       take_irq,
    output logic       wake
);
    typedef struct packed {
        logic [2:0] lvl;
        logic       was7;
    } core_t;

    core_t cs_d, cs_q;

    always_comb begin
        cs_d.lvl  = win_valid ? win_lvl : 3'd0;
        cs_d.was7 = (cs_q.lvl == LVL_NMI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    logic over_mask;
    assign over_mask = (cs_q.lvl != 3'd0) && (cs_q.lvl > cpu_mask);

    assign irq_level = cs_q.lvl;
    assign take_irq  = (cs_q.lvl == LVL_NMI) ? !cs_q.was7 : over_mask;
    assign wake      = stop_mode && ((cs_q.lvl == LVL_NMI) || over_mask);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC     = 16,
    parameter int AW       = $clog2(NSRC + 16),
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    input  logic [2:0]      cpu_mask,
    input  logic            stop_mode,
    output logic [2:0]      irq_level,
    output logic            take_irq,
    input  logic            hw_ack,
    input  logic [2:0]      hw_ack_level,
    output logic [7:0]      hw_vector,
    output logic            wake
);
    localparam int IW      = $clog2(NSRC);
    localparam int SWA_LO  = NSRC + 8;
    localparam int SWA_HI  = NSRC + 15;

    ctrl_t [NSRC-1:0] ctrl_w;
    logic [NSRC-1:0]  mask_w, elig_w;
    logic             gmask_w;

    logic             top_valid, hw_valid, sw_valid;
    logic [IW-1:0]    top_idx, hw_idx, sw_idx;
    logic [2:0]       top_lvl, hw_lvl_unused, sw_lvl_unused;

    logic             sw_sel;
    logic [2:0]       sw_lvl;
    logic [7:0]       sw_vector;
    logic             clr_hw, clr_sw, clr7_en;
    logic [IW-1:0]    clr7_idx;

    assign sw_sel = (int'(reg_addr) >= SWA_LO) && (int'(reg_addr) <= SWA_HI);
    assign sw_lvl = 3'(int'(reg_addr) - SWA_LO);

    assign clr_hw   = hw_ack && (hw_ack_level == LVL_NMI) && hw_valid;
    assign clr_sw   = reg_rd && sw_sel && (sw_lvl == LVL_NMI) && sw_valid;
    assign clr7_en  = clr_hw || clr_sw;
    assign clr7_idx = clr_hw ? hw_idx : sw_idx;

    irq_src_bank #(.NSRC(NSRC), .AW(AW), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .src_req(src_req), .clr7_en(clr7_en), .clr7_idx(clr7_idx),
        .ctrl(ctrl_w), .mask(mask_w), .gmask(gmask_w), .elig(elig_w)
    );

    irq_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb_top (
        .ctrl(ctrl_w), .elig(elig_w), .filt_en(1'b0), .filt_lvl(3'd0),
        .valid(top_valid), .idx(top_idx), .lvl(top_lvl)
    );

    irq_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb_hw (
        .ctrl(ctrl_w), .elig(elig_w), .filt_en(1'b1), .filt_lvl(hw_ack_level),
        .valid(hw_valid), .idx(hw_idx), .lvl(hw_lvl_unused)
    );

    irq_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb_sw (
        .ctrl(ctrl_w), .elig(elig_w), .filt_en(1'b1), .filt_lvl(sw_lvl),
        .valid(sw_valid), .idx(sw_idx), .lvl(sw_lvl_unused)
    );

    irq_core_if u_core (
        .clk(clk), .rst_n(rst_n),
        .win_valid(top_valid), .win_lvl(top_lvl),
        .cpu_mask(cpu_mask), .stop_mode(stop_mode),
        .irq_level(irq_level), .take_irq(take_irq), .wake(wake)
    );

    assign hw_vector = (hw_ack && hw_valid) ? 8'(VEC_BASE + int'(hw_idx)) : 8'(SPUR_VEC);
    assign sw_vector = sw_valid ? 8'(VEC_BASE + int'(sw_idx)) : 8'(SPUR_VEC);

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NSRC)
            reg_rdata[5:0] = ctrl_w[reg_addr[IW-1:0]];
        else if (int'(reg_addr) == NSRC)
            reg_rdata = mask_w;
        else if (int'(reg_addr) == NSRC + 1)
            reg_rdata[0] = gmask_w;
        else if (sw_sel)
            reg_rdata[7:0] = sw_vector;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NSRC     = 16,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] irq_level,
    input logic       take_irq,
    input logic [2:0] cpu_mask,
    input logic       stop_mode,
    input logic       wake,
    input logic [7:0] hw_vector,
    input logic       gmask_w
);
    p_take_above_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && irq_level != 3'd7) |-> (irq_level > cpu_mask));

    p_masked_no_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 3'd0 && irq_level != 3'd7 && irq_level <= cpu_mask) |-> !take_irq);

    p_take_needs_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (irq_level != 3'd0));

    p_nmi_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && irq_level == 3'd7) |=> !(take_irq && irq_level == 3'd7));

    p_gmask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_w |=> (irq_level == 3'd0));

    p_wake_in_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> stop_mode);

    p_vector_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hw_vector) == SPUR_VEC) ||
        (int'(hw_vector) >= VEC_BASE && int'(hw_vector) < VEC_BASE + NSRC));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NSRC(NSRC), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .take_irq(take_irq),
    .cpu_mask(cpu_mask), .stop_mode(stop_mode), .wake(wake),
    .hw_vector(hw_vector), .gmask_w(gmask_w)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    localparam int NSRC  = 16;
    localparam int AW    = 5;
    localparam int TCLK  = 10;
    localparam int SPUR  = 24;
    localparam int BASE  = 64;

    logic            clk = 0, rst_n = 0;
    logic [NSRC-1:0] src_req = '0;
    logic            reg_wr = 0, reg_rd = 0;
    logic [AW-1:0]   reg_addr = '0;
    logic [NSRC-1:0] reg_wdata = '0, reg_rdata;
    logic [2:0]      cpu_mask = 3'd0, irq_level, hw_ack_level = 3'd0;
    logic            stop_mode = 0, take_irq, hw_ack = 0, wake;
    logic [7:0]      hw_vector;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int m_lvl [NSRC];
    int m_sub [NSRC];
    logic [NSRC-1:0] m_mask = '1;
    logic            m_gmask = 1;

    irq_prio_ctrl uut (.*);

    always #(TCLK/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        reg_addr = AW'(a); reg_wdata = NSRC'(d); reg_wr = 1;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic set_ctrl(input int s, input int l, input int p);
        wr(s, l * 8 + p);
        m_lvl[s] = l; m_sub[s] = p;
    endtask

    function automatic bit elig(input int i);
        return m_lvl[i] != 0 && m_lvl[i] != 7 && !m_mask[i] && !m_gmask && src_req[i];
    endfunction

    function automatic int exp_level();
        int b = 0;
        for (int i = 0; i < NSRC; i++) if (elig(i) && m_lvl[i] > b) b = m_lvl[i];
        return b;
    endfunction

    function automatic int exp_vec(input int L);
        int bi = -1;
        for (int i = 0; i < NSRC; i++)
            if (elig(i) && m_lvl[i] == L && (bi < 0 || m_sub[i] > m_sub[bi])) bi = i;
        return (bi < 0) ? SPUR : BASE + bi;
    endfunction

    function automatic int rd_now(input int a);
        return 0;
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int L, s, v;
        void'($urandom(32'd5150));
        for (int i = 0; i < NSRC; i++) begin m_lvl[i] = 0; m_sub[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1; #1;

        // R1 reset state
        reg_addr = 5'd0; #1;      chk(reg_rdata == 0, "R1 ctrl0", int'(reg_rdata), 0);
        reg_addr = AW'(NSRC); #1; chk(reg_rdata == 16'hffff, "R1 mask", int'(reg_rdata), 16'hffff);
        reg_addr = AW'(NSRC+1); #1; chk(reg_rdata == 1, "R1 gmask", int'(reg_rdata), 1);
        chk(irq_level == 0 && !take_irq && !wake, "R1 core outputs", int'(irq_level), 0);
        chk(hw_vector == SPUR, "R1 vector", int'(hw_vector), SPUR);

        // R2 readback and disable
        set_ctrl(5, 3, 6);
        reg_addr = 5'd5; #1; chk(reg_rdata == 16'd30, "R2 readback", int'(reg_rdata), 30);
        wr(NSRC, 0); m_mask = '0; wr(NSRC+1, 0); m_gmask = 0;
        set_ctrl(5, 0, 6); src_req[5] = 1; cyc();
        chk(irq_level == 0, "R2 level0 disables", int'(irq_level), 0);

        // R3 level follows request, not latched
        set_ctrl(5, 4, 1); cyc();
        chk(irq_level == 4, "R3 level", int'(irq_level), 4);
        src_req[5] = 0; cyc();
        chk(irq_level == 0, "R3 no latch", int'(irq_level), 0);

        // R4 strict mask compare
        src_req[5] = 1; cpu_mask = 3'd4; cyc();
        chk(!take_irq, "R4 equal masked", int'(take_irq), 0);
        cpu_mask = 3'd3; #1;
        chk(take_irq, "R4 above mask", int'(take_irq), 1);

        // R10 wake
        stop_mode = 1; #1; chk(wake, "R10 wake set", int'(wake), 1);
        cpu_mask = 3'd5; #1; chk(!wake, "R10 wake masked", int'(wake), 0);
        stop_mode = 0; src_req[5] = 0;

        // R7 sub-priority and index tie-break
        set_ctrl(9, 4, 6); set_ctrl(2, 4, 6);
        src_req[5] = 1; src_req[9] = 1; src_req[2] = 1;
        hw_ack = 1; hw_ack_level = 3'd4; cyc();
        chk(hw_vector == BASE + 2, "R7 tie lowest index", int'(hw_vector), BASE + 2);
        wr(NSRC, 16'h0004); m_mask = 16'h0004; #1;
        chk(hw_vector == BASE + 9, "R7 higher sub", int'(hw_vector), BASE + 9);

        // R6 masks
        wr(NSRC+1, 1); m_gmask = 1; cyc();
        chk(irq_level == 0, "R6 mask-all", int'(irq_level), 0);
        chk(hw_vector == SPUR, "R8 spurious under mask-all", int'(hw_vector), SPUR);
        wr(NSRC+1, 0); m_gmask = 0; wr(NSRC, 16'hffff); m_mask = '1; cyc();
        chk(irq_level == 0, "R6 all masked", int'(irq_level), 0);
        hw_ack = 0; src_req = '0;
        wr(NSRC, 0); m_mask = '0;

        // R5 level 7 edge path
        set_ctrl(3, 7, 0); cpu_mask = 3'd7;
        src_req[3] = 1; cyc();
        chk(irq_level == 0, "R5 nmi latency", int'(irq_level), 0);
        cyc();
        chk(irq_level == 7 && take_irq, "R5 nmi take", int'(take_irq), 1);
        src_req[3] = 0; cyc();
        chk(irq_level == 7 && !take_irq, "R5 latched single pulse", int'(take_irq), 0);
        hw_ack = 1; hw_ack_level = 3'd7; #1;
        chk(hw_vector == BASE + 3, "R8 nmi vector", int'(hw_vector), BASE + 3);
        cyc(); hw_ack = 0; cyc();
        chk(irq_level == 0, "R8 ack clears pending", int'(irq_level), 0);
        src_req[3] = 1; cyc(); cyc();
        chk(irq_level == 7 && take_irq, "R5 retrigger on new edge", int'(take_irq), 1);
        reg_addr = AW'(NSRC + 8 + 7); reg_rd = 1; #1;
        chk(reg_rdata == BASE + 3, "R9 sw ack vector", int'(reg_rdata), BASE + 3);
        cyc(); reg_rd = 0; cyc(); cyc();
        chk(irq_level == 0, "R9 sw ack clears, held req no retrigger", int'(irq_level), 0);
        reg_addr = AW'(NSRC + 8 + 2); #1;
        chk(reg_rdata == SPUR, "R9 spurious", int'(reg_rdata), SPUR);
        src_req = '0; set_ctrl(3, 0, 0);
        for (int i = 0; i < NSRC; i++) if (m_lvl[i] != 0) set_ctrl(i, 0, 0);

        // Random mix, levels 1..6 (R3 R4 R7 R8 R9 R10)
        for (int it = 0; it < 300; it++) begin
            s = int'($urandom_range(NSRC-1, 0));
            set_ctrl(s, int'($urandom_range(6, 1)), int'($urandom_range(7, 0)));
            if ($urandom_range(7, 0) == 0) begin
                v = int'($urandom_range(16'hffff, 0)) & int'($urandom_range(16'hffff, 0));
                wr(NSRC, v); m_mask = NSRC'(v);
            end
            src_req   = NSRC'($urandom);
            cpu_mask  = 3'($urandom_range(6, 0));
            stop_mode = 1'($urandom_range(1, 0));
            L = int'($urandom_range(7, 1));
            hw_ack = 1; hw_ack_level = 3'(L);
            reg_addr = AW'(NSRC + 8 + int'($urandom_range(6, 1)));
            cyc();
            chk(int'(irq_level) == exp_level(), "R3 random level", int'(irq_level), exp_level());
            chk(take_irq == (exp_level() > int'(cpu_mask)), "R4 random take", int'(take_irq),
                int'(exp_level() > int'(cpu_mask)));
            chk(wake == (stop_mode && exp_level() > int'(cpu_mask)), "R10 random wake",
                int'(wake), int'(stop_mode && exp_level() > int'(cpu_mask)));
            chk(int'(hw_vector) == exp_vec(L), "R7 R8 random hw vector", int'(hw_vector), exp_vec(L));
            v = int'(reg_addr) - NSRC - 8;
            chk(int'(reg_rdata) == exp_vec(v), "R9 random sw vector", int'(reg_rdata), exp_vec(v));
        end
        hw_ack = 0;
        finish_up();
    end
endmodule